// File: doc/BRIEF.md
# Peripheral Power and Clock Gating Controller

This block decides, for each of a small number of peripheral instances, whether that instance receives supply power and whether it receives a clock. The decision uses three inputs: the current device mode (Run, Sleep or Deep-Sleep), a clock-gate enable bit per mode and per instance, and a software-writable retention bit per instance.

When the gate enable for the active mode is set, the instance is powered and clocked. When that gate enable is clear, the retention bit chooses between two states. In one the instance is powered but has no clock, so it keeps its state. In the other it is fully off and its state is lost.

The block also issues a one-cycle reset request to an instance whenever the instance must be re-initialised. All outputs are registered. Each one reflects the inputs that were present in the cycle before.

Top module: `pwr_clk_gate_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the register reads 0x0000_0003 and `pwr_en` is all ones. `clk_en` and `rst_req` are all zeros until the first clock edge after release.
- R2: If the gate enable selected by the current mode is 1 for an instance, then on the next clock edge `pwr_en` and `clk_en` for that instance are both 1, whatever its retention bit holds.
- R3: If the selected gate enable is 0 and the instance's retention bit is 0, then on the next edge `pwr_en` and `clk_en` are both 0.
- R4: If the selected gate enable is 0 and the retention bit is 1, then on the next edge `pwr_en` is 1 and `clk_en` is 0.
- R5: The mode code selects the gate-enable vector as follows:
  - 2'b00 (Run) selects `run_gate_en`.
  - 2'b01 (Sleep) selects `sleep_gate_en`.
  - 2'b10 (Deep-Sleep) selects `deep_gate_en`.
  - 2'b11 is treated as Deep-Sleep.
- R6: The register is REG_W bits wide. Bit i is the read/write retention bit of instance i. Bits REG_W-1 down to N_INST are reserved: they always read 0 and writes to them are ignored. A write with `reg_we` high takes effect at the next edge and is visible on `reg_rdata` after that edge. A write also affects the outputs decided at that same edge.
- R7: If the mode class differs from its value in the previous cycle and the newly selected gate enable of an instance is 1, `rst_req` pulses for that instance on the next edge.
- R8: If a write raises an instance's retention bit from 0 to 1, `rst_req` pulses for that instance on the next edge.
- R9: When an instance passes from unpowered to powered, `rst_req` pulses for it on the edge at which `pwr_en` rises. `rst_req` is never 1 while `pwr_en` is 0.
- R10: Each `rst_req` pulse lasts one cycle. It is raised in a following cycle only by a fresh R7, R8 or R9 condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_mode | input | 2 | Device mode code (see R5) |
| run_gate_en | input | N_INST | Per-instance gate enable used in Run |
| sleep_gate_en | input | N_INST | Per-instance gate enable used in Sleep |
| deep_gate_en | input | N_INST | Per-instance gate enable used in Deep-Sleep |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |
| pwr_en | output | N_INST | Per-instance power enable |
| clk_en | output | N_INST | Per-instance clock enable |
| rst_req | output | N_INST | Per-instance one-cycle reset request |

## Verification
The bench builds the block with its defaults: two instances and a 32-bit register. With those values the whole input space is tiny: four mode codes, 64 gate-enable patterns and four retention values. A 4096-step arithmetic sequence therefore visits every combination together with frequent mode changes, retention rises and power loss followed by regain. Each write carries pseudo-random reserved bits, so the ignore rule is checked on every read.

// File: rtl/pwr_clk_gate_ctl.sv
module pwr_clk_gate_ctl #(
  parameter int N_INST = 2,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        dev_mode,
  input  logic [N_INST-1:0] run_gate_en,
  input  logic [N_INST-1:0] sleep_gate_en,
  input  logic [N_INST-1:0] deep_gate_en,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [N_INST-1:0] pwr_en,
  output logic [N_INST-1:0] clk_en,
  output logic [N_INST-1:0] rst_req
);

  localparam int RSVD_W = REG_W - N_INST;
  localparam logic [1:0] MODE_RUN   = 2'b00;
  localparam logic [1:0] MODE_SLEEP = 2'b01;
  localparam logic [1:0] MODE_DEEP  = 2'b10;

  logic [1:0]        cls, cls_q;
  logic [N_INST-1:0] gate_sel, keep_q, keep_d, pwr_d, trig;
  logic              armed;

  assign cls = (dev_mode == 2'b11) ? MODE_DEEP : dev_mode;

  always_comb begin
    case (cls)
      MODE_RUN:   gate_sel = run_gate_en;
      MODE_SLEEP: gate_sel = sleep_gate_en;
      default:    gate_sel = deep_gate_en;
    endcase
  end

  assign keep_d = reg_we ? reg_wdata[N_INST-1:0] : keep_q;
  assign pwr_d  = gate_sel | keep_d;
  assign trig   = ({N_INST{cls != cls_q}} & gate_sel)
                | (keep_d & ~keep_q)
                | ~pwr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_q  <= '1;
      cls_q   <= MODE_RUN;
      pwr_en  <= '1;
      clk_en  <= '0;
      rst_req <= '0;
      armed   <= 1'b0;
    end else begin
      keep_q  <= keep_d;
      cls_q   <= cls;
      pwr_en  <= pwr_d;
      clk_en  <= gate_sel;
      rst_req <= trig & pwr_d;
      armed   <= 1'b1;
    end
  end

  assign reg_rdata = {{RSVD_W{1'b0}}, keep_q};

  generate
    for (genvar i = 0; i < N_INST; i++) begin : g_chk
      AST_REQ_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req[i] |-> pwr_en[i]);  // R9
      AST_CLK_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en[i] |-> pwr_en[i]);  // R4
      AST_GATE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(gate_sel[i]) |-> (clk_en[i] && pwr_en[i]));  // R2
      AST_KEEP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(keep_q[i]) && keep_q[i] |-> rst_req[i]);  // R8
      AST_MODE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        armed && (cls_q != $past(cls_q)) && $past(gate_sel[i]) |-> rst_req[i]);  // R7
      AST_REGAIN: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(pwr_en[i]) && pwr_en[i] |-> rst_req[i]);  // R9
    end
  endgenerate

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(reg_we) |-> keep_q == $past(reg_wdata[N_INST-1:0]));  // R6

endmodule

// File: tb/test_pwr_clk_gate_ctl.sv
module test_pwr_clk_gate_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  dev_mode;
  logic [1:0]  run_gate_en, sleep_gate_en, deep_gate_en;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic [1:0]  pwr_en, clk_en, rst_req;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pwr_clk_gate_ctl i_pwr_clk_gate_ctl (
    .clk(clk), .rst_n(rst_n), .dev_mode(dev_mode),
    .run_gate_en(run_gate_en), .sleep_gate_en(sleep_gate_en),
    .deep_gate_en(deep_gate_en), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwr_en(pwr_en), .clk_en(clk_en), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] m_cls, m_keep, m_pwr;
    rst_n = 1'b0; dev_mode = 2'b00; run_gate_en = 2'b00; sleep_gate_en = 2'b00;
    deep_gate_en = 2'b00; reg_we = 1'b0; reg_wdata = 32'h0;
    repeat (3) @(negedge clk);
    chk("R1 rdata", reg_rdata, 32'h0000_0003);
    chk("R1 pwr_en", {30'h0, pwr_en}, 32'h3);
    chk("R1 clk_en", {30'h0, clk_en}, 32'h0);
    chk("R1 rst_req", {30'h0, rst_req}, 32'h0);
    rst_n = 1'b1;
    chk("R1 rdata after release", reg_rdata, 32'h0000_0003);
    m_cls = 2'b00; m_keep = 2'b11; m_pwr = 2'b11;

    for (int s = 0; s < 4096; s++) begin
      logic [1:0]  md, cl, gs, kd, pd, tr;
      logic [5:0]  g;
      logic        we;
      logic [31:0] wd;
      md = 2'((s * 5 + s / 7) % 4);
      g  = 6'((s * 37 + 11 + s / 64) % 64);
      we = (s % 3) != 0;
      wd = s * 32'h9E37_79B1 + 32'(s / 5);
      dev_mode = md; run_gate_en = g[1:0]; sleep_gate_en = g[3:2];
      deep_gate_en = g[5:4]; reg_we = we; reg_wdata = wd;
      cl = (md == 2'b11) ? 2'b10 : md;
      gs = (cl == 2'b00) ? g[1:0] : (cl == 2'b01) ? g[3:2] : g[5:4];
      kd = we ? wd[1:0] : m_keep;
      pd = gs | kd;
      tr = ((cl != m_cls) ? gs : 2'b00) | (kd & ~m_keep) | ~m_pwr;
      @(negedge clk);
      chk("R3 R4 pwr_en", {30'h0, pwr_en}, {30'h0, pd});
      chk("R2 R5 clk_en", {30'h0, clk_en}, {30'h0, gs});
      chk("R7 R8 R9 R10 rst_req", {30'h0, rst_req}, {30'h0, tr & pd});
      chk("R6 rdata", reg_rdata, {30'h0, kd});
      m_cls = cl; m_keep = kd; m_pwr = pd;
    end
    reg_we = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule